// File: doc/BRIEF.md
# Indexed Real-Time-Clock Register Bank with Periodic Interrupt

This block is the register side of a real-time-clock peripheral. Software reaches it through two byte-wide ports on one bus: an index port and a data port. A write to the index port picks the register that the next data-port access reaches. The top bit of that same write is kept as a flag that masks the non-maskable interrupt elsewhere in the system. Every data-port access, read or write, returns the selection to the status register at 0x0D. Software therefore writes the index again before each access. A read-modify-write of a control register takes four bus cycles: index, read, index, write.

Three registers are involved in the periodic interrupt. A rate register holds a 4-bit rate code. A control register holds the enable bit in bit 6. A flag register reports the cause of the interrupt and clears itself when it is read. A tick generator produces one pulse per period, at the rate chosen by the code. Each pulse sets the periodic flag. When the enable bit is set, the pulse also raises the interrupt output, and the output stays high until software reads the flag register.

Top module: `rtcx_top`

## Requirements
- R1: A write to the index port (`bus_sel`=0) selects the register named by `bus_wdata[6:0]` and copies `bus_wdata[7]` to `nmi_dis_o`. The new value applies from the next clock edge and holds until the next index write.
- R2: After any data-port access (`bus_sel`=1, read or write), the selected index becomes 0x0D at the next clock edge.
- R3: The control register at index 0x0B stores all 8 written bits and reads them back unchanged. Bit 6 enables the periodic interrupt, so read-modify-write through the data port preserves the other bits.
- R4: The rate register at index 0x0A stores all 8 bits. Bits 3:0 hold the rate code n. Code 0 stops the tick. For a nonzero n the period is P = 2^(n-1) clock cycles, counted from the clock edge that writes the register, and the first tick takes effect exactly P edges after that write.
- R5: The flag register at index 0x0C reads as {irq flag, periodic flag, 6'b0}. A data read of it clears both flags, and writes to it have no effect.
- R6: Every tick sets the periodic flag (bit 6). The irq flag (bit 7) and `irq_o` are set only by a tick that occurs while control bit 6 is 1.
- R7: `irq_o` stays high until the flag register is read. A tick in the same cycle as that read keeps the flags set.
- R8: Index 0x0D reads as 0x80. All other indices, apart from 0x0A to 0x0D, read as 0x00. Data writes to 0x0D and to those other indices change no register.
- R9: After reset the index is 0x0D, `nmi_dis_o` is 0, the rate and control registers are 0x00, both flags are clear and `irq_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one cycle is one base period of the tick generator |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_sel | input | 1 | Port select: 0 index port, 1 data port |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the selected register during a data read, else 0 |
| irq_o | output | 1 | Periodic interrupt request |
| nmi_dis_o | output | 1 | Latched non-maskable-interrupt mask flag |

## Verification
The bench builds the block with its defaults: a 7-bit index and a 16-bit tick counter. With these values every rate code can be reached, up to code 15, whose 16384-cycle period still fits in a short run. The bench measures the interrupt edge for codes 1, 2, 3, 5 and 15. Code 1 ticks on every cycle, which lets the bench place a tick on the same cycle as a flag-register read.

// File: rtl/rtcx_pkg.sv
package rtcx_pkg;

  localparam logic [7:0] RTCX_IDX_RATE  = 8'h0A;
  localparam logic [7:0] RTCX_IDX_CTRL  = 8'h0B;
  localparam logic [7:0] RTCX_IDX_FLAG  = 8'h0C;
  localparam logic [7:0] RTCX_IDX_STAT  = 8'h0D;
  localparam logic [7:0] RTCX_STAT_VAL  = 8'h80;
  localparam int         RTCX_PIE_BIT   = 6;

  // Tick period in base cycles for a rate code; 0 means stopped.
  function automatic logic [31:0] rtcx_period(input logic [3:0] code);
    if (code == 4'd0) return 32'd0;
    return 32'd1 << (code - 4'd1);
  endfunction

  // Data-port read value for a given selected index.
  function automatic logic [7:0] rtcx_read_mux(input logic [7:0] sel,
                                               input logic [7:0] rate_reg,
                                               input logic [7:0] ctrl_reg,
                                               input logic       irqf,
                                               input logic       pf);
    case (sel)
      RTCX_IDX_RATE: return rate_reg;
      RTCX_IDX_CTRL: return ctrl_reg;
      RTCX_IDX_FLAG: return {irqf, pf, 6'b0};
      RTCX_IDX_STAT: return RTCX_STAT_VAL;
      default:       return 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/rtcx_index_port.sv
module rtcx_index_port
  import rtcx_pkg::*;
#(
  parameter int IDX_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             idx_wr,
  input  logic             data_acc,
  input  logic [7:0]       wdata,
  output logic [IDX_W-1:0] idx,
  output logic             nmi_dis
);

  localparam logic [IDX_W-1:0] FALLBACK = IDX_W'(RTCX_IDX_STAT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx     <= FALLBACK;
      nmi_dis <= 1'b0;
    end else if (idx_wr) begin
      idx     <= wdata[IDX_W-1:0];
      nmi_dis <= wdata[7];
    end else if (data_acc) begin
      idx     <= FALLBACK;
    end
  end

endmodule

// File: rtl/rtcx_rate_gen.sv
module rtcx_rate_gen
  import rtcx_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] code,
  input  logic       restart,
  output logic       tick
);

  logic [CNT_W-1:0] cnt;
  logic [31:0]      period;
  logic [CNT_W-1:0] limit;
  logic             running;

  always_comb begin
    period  = rtcx_period(code);
    limit   = CNT_W'(period - 32'd1);
    running = (code != 4'd0);
  end

  assign tick = running && (cnt == limit);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (restart || !running || tick) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

endmodule

// File: rtl/rtcx_irq_ctrl.sv
module rtcx_irq_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic pie,
  input  logic clr,
  output logic pf,
  output logic irqf
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pf   <= 1'b0;
      irqf <= 1'b0;
    end else begin
      if (tick)      pf <= 1'b1;
      else if (clr)  pf <= 1'b0;
      if (tick && pie) irqf <= 1'b1;
      else if (clr)    irqf <= 1'b0;
    end
  end

endmodule

// File: rtl/rtcx_top.sv
module rtcx_top
  import rtcx_pkg::*;
#(
  parameter int IDX_W = 7,
  parameter int CNT_W = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_wr,
  input  logic       bus_rd,
  input  logic       bus_sel,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic       irq_o,
  output logic       nmi_dis_o
);

  logic             idx_wr, data_wr, data_rd, data_acc;
  logic [IDX_W-1:0] idx;
  logic [7:0]       idx8;
  logic [7:0]       rate_reg, ctrl_reg;
  logic             tick, pie, pf, irqf, flag_clr, rate_restart;
  logic [3:0]       rate_code;

  assign idx_wr   = bus_wr && !bus_sel;
  assign data_wr  = bus_wr && bus_sel;
  assign data_rd  = bus_rd && bus_sel;
  assign data_acc = data_wr || data_rd;
  assign idx8     = 8'(idx);

  rtcx_index_port #(.IDX_W(IDX_W)) u_index (
    .clk(clk), .rst_n(rst_n), .idx_wr(idx_wr), .data_acc(data_acc),
    .wdata(bus_wdata), .idx(idx), .nmi_dis(nmi_dis_o)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rate_reg <= 8'h00;
      ctrl_reg <= 8'h00;
    end else if (data_wr) begin
      if (idx8 == RTCX_IDX_RATE) rate_reg <= bus_wdata;
      if (idx8 == RTCX_IDX_CTRL) ctrl_reg <= bus_wdata;
    end
  end

  assign rate_code    = rate_reg[3:0];
  assign pie          = ctrl_reg[RTCX_PIE_BIT];
  assign rate_restart = data_wr && (idx8 == RTCX_IDX_RATE);
  assign flag_clr     = data_rd && (idx8 == RTCX_IDX_FLAG);

  rtcx_rate_gen #(.CNT_W(CNT_W)) u_rate (
    .clk(clk), .rst_n(rst_n), .code(rate_code),
    .restart(rate_restart), .tick(tick)
  );

  rtcx_irq_ctrl u_irq (
    .clk(clk), .rst_n(rst_n), .tick(tick), .pie(pie),
    .clr(flag_clr), .pf(pf), .irqf(irqf)
  );

  assign irq_o     = irqf;
  assign bus_rdata = data_rd ? rtcx_read_mux(idx8, rate_reg, ctrl_reg, irqf, pf)
                             : 8'h00;

endmodule

// File: rtl/rtcx_checker.sv
module rtcx_checker
  import rtcx_pkg::*;
#(
  parameter int IDX_W = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_wr,
  input logic             bus_rd,
  input logic             bus_sel,
  input logic [7:0]       bus_wdata,
  input logic [7:0]       bus_rdata,
  input logic             irq_o,
  input logic             nmi_dis_o,
  input logic [IDX_W-1:0] idx,
  input logic             tick,
  input logic             pie,
  input logic [3:0]       rate_code
);

  logic [7:0] idx8;
  assign idx8 = 8'(idx);

  a_r1_nmi_latch: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !bus_sel) |=> (nmi_dis_o == $past(bus_wdata[7])));

  a_r2_fallback: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && (bus_wr || bus_rd)) |=> (idx8 == RTCX_IDX_STAT));

  a_r4_rate_zero_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (rate_code == 4'd0) |-> !tick);

  a_r5_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_sel && idx8 == RTCX_IDX_FLAG && !tick) |=> !irq_o);

  a_r6_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> $past(tick && pie));

  a_r7_irq_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && !(bus_rd && bus_sel && idx8 == RTCX_IDX_FLAG)) |=> irq_o);

  a_r8_status_value: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_sel && idx8 == RTCX_IDX_STAT) |-> (bus_rdata == RTCX_STAT_VAL));

endmodule

bind rtcx_top rtcx_checker #(.IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .bus_sel(bus_sel), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .irq_o(irq_o), .nmi_dis_o(nmi_dis_o), .idx(idx), .tick(tick),
  .pie(pie), .rate_code(rate_code)
);

// File: tb/tb_rtcx_top.sv
module tb_rtcx_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0, bus_sel = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       irq_o, nmi_dis_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #10 clk = ~clk;

  rtcx_top dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_sel(bus_sel), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_o(irq_o), .nmi_dis_o(nmi_dis_o)
  );

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Monitor: compares each data-port read with the queued expectation.
  always @(negedge clk) begin
    if (rst_n && bus_rd && bus_sel) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL scoreboard actual=%0h expected=<none>", bus_rdata);
      end else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(bus_rdata, e, t);
      end
    end
  end

  task automatic bus_write(input logic sel, input logic [7:0] d);
    @(posedge clk); #1;
    bus_wr = 1'b1; bus_sel = sel; bus_wdata = d;
    @(posedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic data_read(input logic [7:0] e, input string tag);
    @(posedge clk); #1;
    bus_rd = 1'b1; bus_sel = 1'b1;
    exp_q.push_back(e); tag_q.push_back(tag);
    @(posedge clk); #1;
    bus_rd = 1'b0;
  endtask

  task automatic reg_write(input logic [7:0] index, input logic [7:0] d);
    bus_write(1'b0, index);
    bus_write(1'b1, d);
  endtask

  task automatic reg_read(input logic [7:0] index, input logic [7:0] e, input string tag);
    bus_write(1'b0, index);
    data_read(e, tag);
  endtask

  // R4/R5: tick edge lands exactly 2^(n-1) edges after the rate write.
  task automatic rate_test(input int n);
    int p;
    p = 1 << (n - 1);
    reg_write(8'h0A, 8'(n));
    for (int k = 1; k < p; k++) begin @(posedge clk); #1; end
    check({7'b0, irq_o}, 8'h00, $sformatf("R4 irq before period code %0d", n));
    @(posedge clk); #1;
    check({7'b0, irq_o}, 8'h01, $sformatf("R4 irq at period code %0d", n));
    reg_write(8'h0A, 8'h00);
    reg_read(8'h0C, 8'hC0, "R5 flag read both set");
    check({7'b0, irq_o}, 8'h00, "R5 irq cleared by flag read");
    reg_read(8'h0C, 8'h00, "R5 flags clear after read");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R9 reset state
    check({7'b0, irq_o}, 8'h00, "R9 irq low after reset");
    check({7'b0, nmi_dis_o}, 8'h00, "R9 nmi flag low after reset");
    data_read(8'h80, "R9 index defaults to status");
    // R1 index with top bit set
    bus_write(1'b0, 8'h8B);
    check({7'b0, nmi_dis_o}, 8'h01, "R1 nmi flag latched high");
    data_read(8'h00, "R9 control reset value");
    data_read(8'h80, "R2 index fell back to status after read");
    reg_read(8'h0A, 8'h00, "R9 rate reset value");
    check({7'b0, nmi_dis_o}, 8'h00, "R1 nmi flag latched low");
    // R3 read-modify-write of control
    reg_write(8'h0B, 8'h25);
    data_read(8'h80, "R2 index fell back to status after write");
    reg_read(8'h0B, 8'h25, "R3 control readback");
    reg_write(8'h0B, 8'h25 | 8'h40);
    reg_read(8'h0B, 8'h65, "R3 read-modify-write preserves bits");
    // R4 code 0 with upper bits stored
    reg_write(8'h0A, 8'h70);
    reg_read(8'h8A, 8'h70, "R4 rate readback upper bits");
    repeat (40) @(posedge clk);
    #1 check({7'b0, irq_o}, 8'h00, "R4 code 0 gives no tick");
    reg_read(8'h0C, 8'h00, "R4 code 0 sets no flag");
    rate_test(1);
    rate_test(2);
    rate_test(3);
    rate_test(5);
    rate_test(15);
    // R6 enable off: periodic flag only
    reg_write(8'h0B, 8'h25);
    reg_write(8'h0A, 8'h01);
    repeat (4) @(posedge clk);
    #1 check({7'b0, irq_o}, 8'h00, "R6 no irq with enable off");
    reg_write(8'h0A, 8'h00);
    reg_read(8'h0C, 8'h40, "R6 periodic flag alone");
    // R7 hold and tick-during-clear
    reg_write(8'h0B, 8'h65);
    reg_write(8'h0A, 8'h01);
    reg_read(8'h0C, 8'hC0, "R7 read with coincident tick");
    check({7'b0, irq_o}, 8'h01, "R7 irq kept by coincident tick");
    reg_write(8'h0A, 8'h00);
    repeat (20) @(posedge clk);
    #1 check({7'b0, irq_o}, 8'h01, "R7 irq held without flag read");
    reg_read(8'h0D, 8'h80, "R8 status read does not clear");
    check({7'b0, irq_o}, 8'h01, "R7 irq held after status read");
    reg_read(8'h0C, 8'hC0, "R5 final clear read");
    check({7'b0, irq_o}, 8'h00, "R5 irq cleared");
    // R8 and R5 ignored writes
    reg_write(8'h0D, 8'h00);
    reg_read(8'h0D, 8'h80, "R8 status write ignored");
    reg_write(8'h20, 8'h55);
    reg_read(8'h20, 8'h00, "R8 unused index reads zero");
    reg_read(8'h0B, 8'h65, "R8 unused write left control intact");
    reg_read(8'h0A, 8'h00, "R8 unused write left rate intact");
    reg_write(8'h0C, 8'hFF);
    reg_read(8'h0C, 8'h00, "R5 flag write ignored");
    repeat (2) @(posedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule